// File: doc/BRIEF.md
# Boot-Time High Fetch Address Generator

This block sits in a small processor front end and turns a 20-bit real-mode linear address into a 32-bit physical address. From reset it forces the address bits above the linear range high on every instruction fetch. Boot code can therefore run from a ROM placed at the very top of the physical address space, even though real-mode addressing only covers one megabyte.

The forcing is held in a one-shot latch. Reset sets it. Near control transfers leave it alone, so the boot code can branch freely inside the top 64 KB. The first far jump or far call clears it on the following clock edge. After that, every fetch lands in the lowest megabyte, and only a new reset arms the latch again.

Data reads and writes never receive the forced bits. A status output reports the latch state. The address path is combinational: a request is answered in the same cycle it is presented.

Top module: `hfg_top`

## Requirements
- R1: While forcing is active, a code fetch (`req_vld`=1, `req_code`=1) drives every address bit from LA_W up to PA_W-1 to 1.
- R2: A cycle with `rst`=1 sets forcing, so `boot_hi` reads 1 from the next clock edge onward until a far transfer clears it.
- R3: With the default widths, the first code fetch after reset at linear address 0xFFFF0 produces physical address 0xFFFFFFF0.
- R4: A near-transfer pulse (`near_xfer`=1) with no far pulse leaves `boot_hi` and the forced upper bits unchanged.
- R5: A far-transfer pulse (`far_xfer`=1) clears `boot_hi` at the next clock edge. A fetch presented in the same cycle as the pulse is still forced. A far pulse wins over a simultaneous near pulse.
- R6: Once cleared, forcing stays off whatever far or near pulses follow. Only `rst` sets it again.
- R7: A data access (`req_vld`=1, `req_code`=0) always drives the upper bits to 0, whether forcing is active or not.
- R8: Bits 0 to LA_W-1 of `phys_addr` always equal `req_lin`. When forcing is off, a code fetch drives the upper bits to 0, so the address falls in the lowest 2^LA_W bytes.
- R9: While `rst`=1, `phys_vld` is 0 regardless of `req_vld`.
- R10: Outside reset, `phys_vld` equals `req_vld` in the same cycle, and `phys_addr` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; arms forcing |
| req_vld | input | 1 | Access request strobe |
| req_code | input | 1 | 1 = instruction fetch, 0 = data access |
| req_lin | input | LA_W | Real-mode linear address |
| near_xfer | input | 1 | Pulse: near (intrasegment) control transfer decoded |
| far_xfer | input | 1 | Pulse: far (intersegment) jump or call decoded |
| phys_vld | output | 1 | Physical address valid |
| phys_addr | output | PA_W | Composed physical address |
| boot_hi | output | 1 | Forcing latch state |

## Verification
The bench builds two instances from the same stimulus. The first uses the default widths (PA_W=32, LA_W=20) and covers the 0xFFFFFFF0 reset-vector case exactly. The second uses PA_W=24 and LA_W=16. In that instance the forced field is only 8 bits wide and sits at a different position, which exposes any fill that is tied to fixed bit positions rather than derived from the parameters. The random phase mixes resets, near pulses and far pulses, so both instances are driven through repeated arm and clear cycles as well as through far pulses that arrive while forcing is already off.

// File: rtl/hfg_pkg.sv
package hfg_pkg;

    // Registered state of the boot forcing latch
    typedef struct packed {
        logic armed;    // 1: upper fetch address bits forced high
    } hfg_state_t;

    localparam hfg_state_t HFG_RESET_STATE = '{armed: 1'b1};

endpackage

// File: rtl/hfg_force_latch.sv
module hfg_force_latch
    import hfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic near_xfer,
    input  logic far_xfer,
    output logic force_on
);

    hfg_state_t state_d;
    hfg_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d = HFG_RESET_STATE;
        end else if (far_xfer) begin
            // A near pulse in the same cycle does not matter: far wins
            state_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign force_on = state_q.armed;

    AST_FAR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        far_xfer |=> !force_on); // R5

    AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (!force_on && !rst) |=> !force_on); // R6

    AST_NEAR_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (force_on && near_xfer && !far_xfer) |=> force_on); // R4

    // near_xfer only matters through the assertions above
    logic unused_near;
    assign unused_near = near_xfer;

endmodule

// File: rtl/hfg_addr_compose.sv
module hfg_addr_compose #(
    parameter int PA_W = 32,
    parameter int LA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            force_on,
    input  logic            req_vld,
    input  logic            req_code,
    input  logic [LA_W-1:0] req_lin,
    output logic [PA_W-1:0] phys_addr
);

    localparam int HI_W = PA_W - LA_W;

    logic [HI_W-1:0] hi_d;
    logic            fill_d;

    always_comb begin
        fill_d = force_on & req_code;
    end

    // One fill bit per upper address line
    for (genvar gi = 0; gi < HI_W; gi++) begin : g_hi
        assign hi_d[gi] = fill_d;
    end

    assign phys_addr = {hi_d, req_lin};

    AST_CODE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_code && force_on) |-> (&phys_addr[PA_W-1:LA_W])); // R1

    AST_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !req_code) |-> (phys_addr[PA_W-1:LA_W] == '0)); // R7

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (phys_addr[LA_W-1:0] == req_lin)); // R8

endmodule

// File: rtl/hfg_top.sv
module hfg_top #(
    parameter int PA_W = 32,
    parameter int LA_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_vld,
    input  logic            req_code,
    input  logic [LA_W-1:0] req_lin,
    input  logic            near_xfer,
    input  logic            far_xfer,
    output logic            phys_vld,
    output logic [PA_W-1:0] phys_addr,
    output logic            boot_hi
);

    logic force_on;

    hfg_force_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .near_xfer (near_xfer),
        .far_xfer  (far_xfer),
        .force_on  (force_on)
    );

    hfg_addr_compose #(
        .PA_W (PA_W),
        .LA_W (LA_W)
    ) u_compose (
        .clk       (clk),
        .rst       (rst),
        .force_on  (force_on),
        .req_vld   (req_vld),
        .req_code  (req_code),
        .req_lin   (req_lin),
        .phys_addr (phys_addr)
    );

    // No request is honoured while reset is held
    assign phys_vld = req_vld & ~rst;
    assign boot_hi  = force_on;

    always_comb begin
        if (rst) begin
            AST_NO_VLD_IN_RST: assert (!phys_vld); // R9
        end
    end

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        phys_vld == req_vld); // R10

endmodule

// File: tb/tb_hfg_top.sv
`timescale 1ns/1ps
module tb_hfg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic        req_code = 1'b0;
    logic [19:0] req_lin = '0;
    logic        near_xfer = 1'b0;
    logic        far_xfer = 1'b0;

    logic        phys_vld, phys_vld_w;
    logic [31:0] phys_addr;
    logic [23:0] phys_addr_w;
    logic        boot_hi, boot_hi_w;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit m_force = 1'b1;

    always #2.5 clk = ~clk;

    hfg_top dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_code(req_code),
        .req_lin(req_lin), .near_xfer(near_xfer), .far_xfer(far_xfer),
        .phys_vld(phys_vld), .phys_addr(phys_addr), .boot_hi(boot_hi)
    );

    hfg_top #(.PA_W(24), .LA_W(16)) dut_w (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_code(req_code),
        .req_lin(req_lin[15:0]), .near_xfer(near_xfer), .far_xfer(far_xfer),
        .phys_vld(phys_vld_w), .phys_addr(phys_addr_w), .boot_hi(boot_hi_w)
    );

    function automatic logic [31:0] exp_addr(input bit f, input bit code,
                                             input logic [19:0] lin,
                                             input int pa, input int la);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < la)      r[i] = lin[i];
            else if (i < pa) r[i] = f & code;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check 1 ns later, then advance the model
    task automatic step(input bit r, input bit v, input bit c, input logic [19:0] lin,
                        input bit nr, input bit fr);
        string tag;
        @(negedge clk);
        rst = r; req_vld = v; req_code = c; req_lin = lin;
        near_xfer = nr; far_xfer = fr;
        #1;
        chk("R2 boot_hi", {31'b0, boot_hi}, {31'b0, m_force});
        chk("R6 boot_hi narrow", {31'b0, boot_hi_w}, {31'b0, m_force});
        chk(r ? "R9 phys_vld" : "R10 phys_vld", {31'b0, phys_vld}, {31'b0, v & ~r});
        chk(r ? "R9 phys_vld narrow" : "R10 phys_vld narrow", {31'b0, phys_vld_w}, {31'b0, v & ~r});
        if (v && !r) begin
            tag = !c ? "R7 data addr" : (m_force ? "R1 forced addr" : "R8 unforced addr");
            chk(tag, phys_addr, exp_addr(m_force, c, lin, 32, 20));
            chk({tag, " narrow"}, {8'h0, phys_addr_w}, exp_addr(m_force, c, lin, 24, 16));
        end
        if (r)       m_force = 1'b1;
        else if (fr) m_force = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C));
        // R9: requests during reset are not honoured
        for (int i = 0; i < 3; i++) step(1, 1, 1, 20'hFFFF0, 0, 0);
        // R3: first fetch goes to the top-of-space vector
        step(0, 1, 1, 20'hFFFF0, 0, 0);
        chk("R3 reset vector", phys_addr, 32'hFFFFFFF0);
        // R4: near transfer keeps forcing
        step(0, 1, 1, 20'hFFFF3, 1, 0);
        step(0, 1, 1, 20'hF0100, 0, 0);
        chk("R4 still forced", phys_addr, 32'hFFFF0100);
        // R7: data access while forced
        step(0, 1, 0, 20'h00420, 0, 0);
        chk("R7 data low", phys_addr, 32'h00000420);
        // R5: same-cycle fetch still forced, far and near together
        step(0, 1, 1, 20'hFFF00, 1, 1);
        chk("R5 same-cycle fetch forced", phys_addr, 32'hFFFFFF00);
        step(0, 1, 1, 20'h07C00, 0, 0);
        chk("R5 target fetch low", phys_addr, 32'h00007C00);
        chk("R5 boot_hi cleared", {31'b0, boot_hi}, 32'h0);
        // R6: later far pulses have no effect
        step(0, 1, 1, 20'h12345, 0, 1);
        step(0, 1, 1, 20'hFFFFF, 0, 0);
        chk("R6 no rearm", phys_addr, 32'h000FFFFF);
        // R2: reset arms again
        step(1, 0, 0, 20'h0, 0, 0);
        step(0, 1, 1, 20'h00000, 0, 0);
        chk("R2 rearmed", phys_addr, 32'hFFF00000);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 200) == 0, ($urandom % 4) != 0, ($urandom % 3) != 0,
                 20'($urandom), ($urandom % 8) == 0, ($urandom % 40) == 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule